// File: doc/BRIEF.md
# Counter-Flow Systolic Polynomial Multiplier

This block multiplies two polynomials of the same degree `DEG` with unsigned coefficients. The result is the list of the `2*DEG+1` product coefficients. The operation takes place in a linear chain of `DEG+1` identical cells. One operand's coefficients enter at the left end of the chain and move right. The other operand's coefficients enter at the right end and move left. Each operand moves to the nearest neighbour only. Once an operand's real coefficients are used up, its feeder supplies zeros. The operand registers advance once every second cycle. Between two advances the chain produces two sums. The first sum adds the products of pairs that sit in the same cell. The second adds the products of pairs that are about to swap places between neighbouring cells. In this way every pair `a_i, b_j` meets exactly once.

A caller places both operands on the coefficient buses and pulses `start`. The product then appears as a burst. There is one coefficient per cycle, in ascending order. The timing is fixed relative to the accepted start, so no handshake is needed.

Top module: `cfpoly_mult`

## Requirements
- R1: Each output beat with index k (k = 0 .. 2*DEG) carries c_k = sum over i of a_i*b_(k-i), summed over the indices i for which both a_i and b_(k-i) exist. Coefficient i of each operand sits at bits [i*CW +: CW] of its bus.
- R2: The beats of one product come in ascending order of k, with exactly one beat per cycle and no gaps.
- R3: A start is accepted on a rising clock edge if the block is idle at that edge. Call that edge number 0. Coefficient c_0 is then presented after edge DEG+1, and c_k after edge DEG+1+k.
- R4: `out_valid` is high for exactly 2*DEG+1 consecutive cycles per accepted start.
- R5: `out_last` is high only together with `out_valid`, and only on the beat that carries c_(2*DEG).
- R6: A start sampled on any edge from the accepting edge up to and including the edge that raises `out_last` is ignored: it produces no extra beats and changes no beat. A start sampled while `out_last` is high is accepted.
- R7: Each accepted start clears all operand state. A product never contains a contribution from an earlier operation.
- R8: After synchronous reset, `out_valid` and `out_last` are low and `out_coef` is zero.
- R9: Coefficients at full scale (all ones) produce exact results. The output width is 2*CW + clog2(DEG+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiplication |
| a_coefs | input | (DEG+1)*CW | First operand, coefficient i at bits [i*CW +: CW] |
| b_coefs | input | (DEG+1)*CW | Second operand, same layout |
| out_coef | output | 2*CW+clog2(DEG+1) | Product coefficient of the current beat |
| out_valid | output | 1 | Beat carries a product coefficient |
| out_last | output | 1 | Beat carries the highest coefficient |

## Verification
The bound checker checks the shape of every burst on every cycle. It checks that the first beat comes exactly DEG+1 cycles after an accepted start. It checks that the valid window is contiguous and exactly 2*DEG+1 beats long. It checks that the last flag appears only at the end of that window and only together with valid. The numerical content cannot be seen from properties alone. This covers the convolution values, the zero padding at both ends, full-scale operands, and the absence of residue from the previous operand set. Only the bench's scoreboard shows these, against sums it computes itself. The same holds for how starts are treated while a burst is running and immediately after the last beat.

// File: rtl/cfpm_pkg.sv
`timescale 1ns/1ps
package cfpm_pkg;
    localparam int unsigned DEG_DEF = 3;
    localparam int unsigned CW_DEF  = 8;

    // Operand registers move on PH_SHIFT edges and hold on PH_HOLD edges.
    typedef enum logic {PH_SHIFT = 1'b0, PH_HOLD = 1'b1} phase_e;

    typedef struct packed {
        logic valid;
        logic last;
    } beat_flags_t;

    function automatic int unsigned sum_width(int unsigned cw, int unsigned deg);
        return 2 * cw + $clog2(deg + 1);
    endfunction
endpackage

// File: rtl/cfpm_feeder.sv
`timescale 1ns/1ps
// Boundary queue: it is loaded with the remaining coefficients and releases
// one per shift, then zeros.
module cfpm_feeder #(
    parameter int unsigned DEPTH = 3,
    parameter int unsigned CW    = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  shift,
    input  logic [DEPTH*CW-1:0]   load_vec,
    output logic [CW-1:0]         head
);
    logic [CW-1:0] q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) q[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < int'(DEPTH); i++) q[i] <= load_vec[i*CW +: CW];
        end else if (shift) begin
            for (int i = 0; i < int'(DEPTH) - 1; i++) q[i] <= q[i+1];
            q[DEPTH-1] <= '0;
        end
    end

    assign head = q[0];
endmodule

// File: rtl/cfpm_cell.sv
`timescale 1ns/1ps
// One cell: a right-moving and a left-moving operand register, plus two
// partial-sum stages (pair held here, pair crossing toward the right neighbour).
module cfpm_cell #(
    parameter int unsigned CW = 8,
    parameter int unsigned SW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          shift,
    input  logic [CW-1:0] a_init,
    input  logic [CW-1:0] b_init,
    input  logic [CW-1:0] a_from_left,
    input  logic [CW-1:0] b_from_right,
    input  logic [CW-1:0] b_ahead,
    input  logic [SW-1:0] meet_sum_in,
    input  logic [SW-1:0] pass_sum_in,
    output logic [CW-1:0] a_q,
    output logic [CW-1:0] b_q,
    output logic [SW-1:0] meet_sum_out,
    output logic [SW-1:0] pass_sum_out
);
    logic [2*CW-1:0] meet_prod;
    logic [2*CW-1:0] pass_prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= a_init;
            b_q <= b_init;
        end else if (shift) begin
            a_q <= a_from_left;
            b_q <= b_from_right;
        end
    end

    always_comb begin
        meet_prod    = a_q * b_q;
        pass_prod    = a_q * b_ahead;
        meet_sum_out = meet_sum_in + {{(SW-2*CW){1'b0}}, meet_prod};
        pass_sum_out = pass_sum_in + {{(SW-2*CW){1'b0}}, pass_prod};
    end
endmodule

// File: rtl/cfpm_seq.sv
`timescale 1ns/1ps
// Burst sequencer: it accepts a start when idle, alternates the phases and
// frames the output window.
module cfpm_seq
    import cfpm_pkg::*;
#(
    parameter int unsigned DEG = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        busy,
    output logic        load,
    output logic        shift,
    output logic        sel_meet,
    output beat_flags_t flags
);
    localparam int unsigned FIRST_EDGE = DEG + 1;
    localparam int unsigned LAST_EDGE  = 3 * DEG + 1;
    localparam int unsigned CNTW       = $clog2(LAST_EDGE + 1);

    logic [CNTW-1:0] cnt;
    phase_e          ph;

    assign load     = start && !busy;
    assign shift    = busy && (ph == PH_SHIFT);
    assign sel_meet = (ph == PH_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            ph    <= PH_SHIFT;
            cnt   <= '0;
            flags <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            ph    <= PH_HOLD;
            cnt   <= CNTW'(1);
            flags <= '0;
        end else if (busy) begin
            ph          <= (ph == PH_HOLD) ? PH_SHIFT : PH_HOLD;
            cnt         <= cnt + 1'b1;
            flags.valid <= (cnt >= CNTW'(FIRST_EDGE)) && (cnt <= CNTW'(LAST_EDGE));
            flags.last  <= (cnt == CNTW'(LAST_EDGE));
            if (cnt == CNTW'(LAST_EDGE)) busy <= 1'b0;
        end else begin
            flags <= '0;
        end
    end
endmodule

// File: rtl/cfpoly_mult.sv
`timescale 1ns/1ps
module cfpoly_mult
    import cfpm_pkg::*;
#(
    parameter  int unsigned DEG = DEG_DEF,
    parameter  int unsigned CW  = CW_DEF,
    localparam int unsigned SW  = sum_width(CW, DEG)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [(DEG+1)*CW-1:0] a_coefs,
    input  logic [(DEG+1)*CW-1:0] b_coefs,
    output logic [SW-1:0]         out_coef,
    output logic                  out_valid,
    output logic                  out_last
);
    localparam int unsigned NCELL = DEG + 1;

    logic        busy_w, load_w, shift_w, sel_meet_w;
    beat_flags_t flags_w;
    logic [CW-1:0] a_head, b_head;

    logic [CW-1:0] a_q      [NCELL];
    logic [CW-1:0] b_q      [NCELL];
    logic [CW-1:0] a_left_w [NCELL];
    logic [CW-1:0] b_right_w[NCELL];
    logic [CW-1:0] b_ahead_w[NCELL];
    logic [CW-1:0] a_init_w [NCELL];
    logic [CW-1:0] b_init_w [NCELL];
    logic [SW-1:0] meet_chain[NCELL+1];
    logic [SW-1:0] pass_chain[NCELL+1];

    cfpm_seq #(.DEG(DEG)) u_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy_w), .load(load_w),
        .shift(shift_w), .sel_meet(sel_meet_w), .flags(flags_w)
    );

    cfpm_feeder #(.DEPTH(DEG), .CW(CW)) u_feed_a (
        .clk(clk), .rst(rst), .load(load_w), .shift(shift_w),
        .load_vec(a_coefs[(DEG+1)*CW-1:CW]), .head(a_head)
    );

    cfpm_feeder #(.DEPTH(DEG), .CW(CW)) u_feed_b (
        .clk(clk), .rst(rst), .load(load_w), .shift(shift_w),
        .load_vec(b_coefs[(DEG+1)*CW-1:CW]), .head(b_head)
    );

    assign meet_chain[0] = '0;
    assign pass_chain[0] = '0;

    for (genvar p = 0; p < int'(NCELL); p++) begin : g_cell
        if (p == 0) begin : g_left_edge
            assign a_left_w[p] = a_head;
            assign a_init_w[p] = a_coefs[0 +: CW];
        end else begin : g_left_inner
            assign a_left_w[p] = a_q[p-1];
            assign a_init_w[p] = '0;
        end

        if (p == int'(DEG)) begin : g_right_edge
            assign b_right_w[p] = b_head;
            assign b_ahead_w[p] = '0;
            assign b_init_w[p]  = b_coefs[0 +: CW];
        end else begin : g_right_inner
            assign b_right_w[p] = b_q[p+1];
            assign b_ahead_w[p] = b_q[p+1];
            assign b_init_w[p]  = '0;
        end

        cfpm_cell #(.CW(CW), .SW(SW)) u_cell (
            .clk(clk), .rst(rst), .load(load_w), .shift(shift_w),
            .a_init(a_init_w[p]), .b_init(b_init_w[p]),
            .a_from_left(a_left_w[p]), .b_from_right(b_right_w[p]),
            .b_ahead(b_ahead_w[p]),
            .meet_sum_in(meet_chain[p]), .pass_sum_in(pass_chain[p]),
            .a_q(a_q[p]), .b_q(b_q[p]),
            .meet_sum_out(meet_chain[p+1]), .pass_sum_out(pass_chain[p+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_coef <= '0;
        end else if (busy_w) begin
            out_coef <= sel_meet_w ? meet_chain[NCELL] : pass_chain[NCELL];
        end
    end

    assign out_valid = flags_w.valid;
    assign out_last  = flags_w.last;
endmodule

// File: rtl/cfpoly_mult_chk.sv
`timescale 1ns/1ps
module cfpoly_mult_chk #(
    parameter int unsigned DEG = 3
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic out_valid,
    input logic out_last
);
    localparam int unsigned BURST = 2 * DEG + 1;
    localparam int unsigned RW    = $clog2(BURST + 1) + 1;
    localparam int unsigned TW    = $clog2(3 * DEG + 3) + 1;

    logic [RW-1:0] run_len;
    logic [TW-1:0] since;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            since   <= '1;
        end else begin
            if (out_valid) begin
                if (run_len != '1) run_len <= run_len + 1'b1;
            end else begin
                run_len <= '0;
            end
            if (start && !busy)  since <= '0;
            else if (since != '1) since <= since + 1'b1;
        end
    end

    assert_last_valid_R5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_burst_len_R4: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (run_len == RW'(2 * DEG)));

    assert_clean_end_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_last));

    assert_no_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    assert_first_beat_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (since == TW'(DEG + 1)));
endmodule

bind cfpoly_mult cfpoly_mult_chk #(.DEG(DEG)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy_w),
    .out_valid(out_valid), .out_last(out_last)
);

// File: tb/sim_cfpoly_mult.sv
`timescale 1ns/1ps
module sim_cfpoly_mult;
    import cfpm_pkg::*;

    localparam int unsigned DEG   = 3;
    localparam int unsigned CW    = 8;
    localparam int unsigned SW    = sum_width(CW, DEG);
    localparam int          NC    = DEG + 1;
    localparam int          BURST = 2 * DEG + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [NC*CW-1:0] a_bus = '0;
    logic [NC*CW-1:0] b_bus = '0;
    logic [SW-1:0] out_coef;
    logic out_valid, out_last;

    cfpoly_mult #(.DEG(DEG), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .a_coefs(a_bus), .b_coefs(b_bus),
        .out_coef(out_coef), .out_valid(out_valid), .out_last(out_last)
    );

    always #2.5 clk = ~clk;

    int     errors = 0;
    int     checks = 0;
    longint cyc = 0;
    int     run_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int     k;
        longint val;
        longint when;
    } exp_t;

    exp_t sbq[$];
    exp_t cur;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Called at a negedge: drives one start and queues the expected burst.
    task automatic launch(input int a[NC], input int b[NC]);
        longint base;
        for (int p = 0; p < NC; p++) begin
            a_bus[p*CW +: CW] = CW'(a[p]);
            b_bus[p*CW +: CW] = CW'(b[p]);
        end
        start = 1'b1;
        base  = cyc + DEG + 2;
        for (int k = 0; k < BURST; k++) begin
            longint s = 0;
            for (int i = 0; i < NC; i++) begin
                int j = k - i;
                if (j >= 0 && j < NC) s += longint'(a[i]) * longint'(b[j]);
            end
            sbq.push_back('{k: k, val: s, when: base + k});
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (sbq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (out_last && !out_valid) check(1'b0, "R5", "last without valid", 1, 0);
            if (out_valid) begin
                run_cnt++;
                if (sbq.size() == 0) begin
                    check(1'b0, "R6", "unexpected beat", longint'(out_coef), 0);
                end else begin
                    cur = sbq.pop_front();
                    check(longint'(out_coef) == cur.val, "R1", $sformatf("c_%0d value", cur.k),
                          longint'(out_coef), cur.val);
                    check(cyc == cur.when, (cur.k == 0) ? "R3" : "R2",
                          $sformatf("c_%0d cycle", cur.k), cyc, cur.when);
                    check(out_last == (cur.k == 2 * DEG), "R5", $sformatf("c_%0d last flag", cur.k),
                          longint'(out_last), longint'(cur.k == 2 * DEG));
                end
            end else if (run_cnt != 0) begin
                check(run_cnt == BURST, "R4", "burst length", run_cnt, BURST);
                run_cnt = 0;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "valid after reset", longint'(out_valid), 0);
        check(out_last == 1'b0, "R8", "last after reset", longint'(out_last), 0);
        check(out_coef == '0, "R8", "coef after reset", longint'(out_coef), 0);

        // R1: general operands
        launch('{1, 2, 3, 4}, '{5, 6, 7, 8});
        wait_idle();
        // R1: only the top coefficients set, zero padding at both ends
        launch('{0, 0, 0, 1}, '{0, 0, 0, 1});
        wait_idle();
        // R1: single constant term against a full operand
        launch('{7, 0, 0, 0}, '{1, 2, 3, 4});
        wait_idle();
        // R9: full-scale coefficients
        launch('{255, 255, 255, 255}, '{255, 255, 255, 255});
        wait_idle();

        // R6 / R7: full-scale run, then a new start while last is visible
        launch('{255, 255, 255, 255}, '{255, 255, 255, 255});
        while (!out_last) @(negedge clk);
        launch('{2, 0, 1, 3}, '{1, 1, 0, 2});
        wait_idle();

        // R6: starts during a running burst are ignored
        launch('{3, 1, 4, 1}, '{5, 9, 2, 6});
        repeat (3) @(negedge clk);
        a_bus = {NC{8'hAA}};
        b_bus = {NC{8'h55}};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (3 * DEG + 6) @(negedge clk);
        check(out_valid == 1'b0, "R6", "no burst from ignored start", longint'(out_valid), 0);
        check(sbq.size() == 0, "R2", "pending beats", sbq.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual=%0d expected=%0d pending beats", sbq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule